// File: doc/BRIEF.md
# Segmented Virtual Address Translator

This block turns a 32-bit virtual address into a physical address for an instruction fetch, a data load or a data store. When the access cannot complete, it returns a fault code instead. Two kernel windows of the address space are mapped directly, with no lookup: one is restricted to kernel mode and the other is not. All other addresses go through a page-pair entry held in an external table. The block drives a probe (page number and address-space id) to that table. In the same cycle, the table answers with the matching entry: whether it hit, the page shift, an even and an odd frame number, and valid and dirty bits for each half.

Requests enter on a valid/ready channel. Each accepted request produces exactly one result on a valid/ready response channel, one cycle later. A result that is not taken stays on the response port unchanged. While it waits, `req_ready` is low, so back-pressure travels straight to the requester. The result carries the physical address, an uncacheable flag, the fault code and, for a faulting access, the fields a handler needs: the faulting address, the page-pair number, the two small-page bits and the address-space id.

Top module: `vaddr_xlate`

## Requirements
- R1: `req_ready` equals `!resp_valid || resp_ready`. A request accepted on a clock edge is presented with `resp_valid` high after that edge. While `resp_valid` is high and `resp_ready` is low, every response field holds its value.
- R2: `probe_vpn` is `req_va[31:11]`, with its two low bits forced to 0 unless `small_pages` is 1. `probe_asid` is `req_asid`.
- R3: The mode is kernel when any status bit in mask 0x10000006 is set, or when status bits [4:3] are 00. Otherwise it is not kernel (01 supervisor, 10 user, 11 invalid). An access to 0x80000000–0x9FFFFFFF outside kernel mode, or a misaligned access there, faults with code 1 for a fetch and code 2 for a load or store.
- R4: Addresses in 0x80000000–0xBFFFFFFF bypass the table, and their physical address is `{3'b000, va[28:0]}`. The window 0xA0000000–0xBFFFFFFF never faults, whatever the mode or alignment.
- R5: A misaligned access to any other address faults with code 1 (fetch) or 2 (load/store), whatever the table returns.
- R6: A table miss faults with code 3 for a fetch and code 4 for a load or store.
- R7: The virtual address bit at the entry's page shift selects the half: 0 selects even, 1 selects odd. A hit on a half whose valid bit is clear faults with code 5 (fetch) or 6 (load/store).
- R8: A store (`req_kind` = 2) that hits a valid half whose dirty bit is clear faults with code 7. Loads (`req_kind` 1 or 3) and fetches (`req_kind` 0) ignore the dirty bit.
- R9: For a fault-free mapped access with a page shift S (12..28), the physical address is `((frame >> (S-12)) << S) | (va & ((1<<S)-1))`.
- R10: On codes 3 to 7, `resp_bad_va` is the request address, `resp_vpn2` is `probe_vpn[20:2]`, `resp_vpn2x` is `probe_vpn[1:0]` and `resp_asid` is the request id. On codes 1 and 2, only `resp_bad_va` is filled and the other three are 0. With code 0, all four are 0.
- R11: `resp_uncached` is 1 exactly when there is no fault and `va & 0xA0000000` equals 0xA0000000.
- R12: Priority runs: address error, refill, invalid, modified. Whenever the fault code is nonzero, `resp_pa` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when high |
| req_va | input | 32 | Virtual address |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 load |
| req_misaligned | input | 1 | Access is misaligned |
| req_asid | input | 8 | Address-space id of the request |
| status_word | input | 32 | Processor status word |
| small_pages | input | 1 | 1 KB page mode |
| probe_vpn | output | 21 | Page number sent to the entry table |
| probe_asid | output | 8 | Address-space id sent to the entry table |
| ent_hit | input | 1 | Table found a matching entry |
| ent_page_shift | input | 5 | log2 of the page size of the hit entry |
| ent_pfn_even | input | 20 | Even-half frame number, 4 KB units |
| ent_pfn_odd | input | 20 | Odd-half frame number, 4 KB units |
| ent_valid_even | input | 1 | Even half valid |
| ent_valid_odd | input | 1 | Odd half valid |
| ent_dirty_even | input | 1 | Even half writable |
| ent_dirty_odd | input | 1 | Odd half writable |
| resp_valid | output | 1 | Result present |
| resp_ready | input | 1 | Consumer takes the result |
| resp_pa | output | 32 | Physical address, 0 on a fault |
| resp_uncached | output | 1 | Access bypasses caches |
| resp_fault | output | 4 | Fault code 0..7 |
| resp_bad_va | output | 32 | Faulting virtual address |
| resp_vpn2 | output | 19 | Page-pair number of the fault |
| resp_vpn2x | output | 2 | Small-page bits of the fault |
| resp_asid | output | 8 | Address-space id of the fault |

## Verification
The assertions assume the entry table answers within the request cycle. They also assume its fields stay stable while a request waits for `req_ready`, and that `req_valid` is never high during reset. The bench models the table as plain registers. It sets them before it raises `req_valid` and leaves them unchanged until the result has been sampled. Every page shift it uses lies between 12 and 28, so the frame arithmetic stays in the range the requirements define.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int VA_W = 32;
  localparam int PA_W = 32;
  localparam int VPN_W = VA_W - 11;
  localparam int VPN2_W = VPN_W - 2;
  localparam logic [31:0] KERN_MASK = 32'h1000_0006;
  localparam logic [31:0] UNCACHE_PAT = 32'hA000_0000;

  typedef enum logic [3:0] {
    F_NONE     = 4'd0,
    F_ADDR_I   = 4'd1,
    F_ADDR_D   = 4'd2,
    F_REFILL_I = 4'd3,
    F_REFILL_D = 4'd4,
    F_INVAL_I  = 4'd5,
    F_INVAL_D  = 4'd6,
    F_MOD      = 4'd7
  } fault_e;

  typedef enum logic [1:0] {
    MODE_KERN = 2'd0,
    MODE_SUP  = 2'd1,
    MODE_USER = 2'd2,
    MODE_BAD  = 2'd3
  } op_mode_e;
endpackage

// File: rtl/xlate_mode_dec.sv
module xlate_mode_dec
  import xlate_pkg::*;
(
  input  logic [31:0] status_word,
  output op_mode_e    mode
);
  always_comb begin
    if (((status_word & KERN_MASK) != 32'h0) || (status_word[4:3] == 2'b00))
      mode = MODE_KERN;
    else if (status_word[4:3] == 2'b01)
      mode = MODE_SUP;
    else if (status_word[4:3] == 2'b10)
      mode = MODE_USER;
    else
      mode = MODE_BAD;
  end
endmodule

// File: rtl/xlate_segment.sv
module xlate_segment
  import xlate_pkg::*;
(
  input  logic [VA_W-1:0] va,
  output logic            in_kwin_priv,
  output logic            in_kwin_open,
  output logic [PA_W-1:0] direct_pa
);
  assign in_kwin_priv = (va[VA_W-1 -: 3] == 3'b100);
  assign in_kwin_open = (va[VA_W-1 -: 3] == 3'b101);
  assign direct_pa    = {3'b000, va[VA_W-4:0]};
endmodule

// File: rtl/xlate_page_map.sv
module xlate_page_map
  import xlate_pkg::*;
#(
  parameter int PFN_W = 20,
  parameter int BASE_SHIFT = 12
) (
  input  logic [VA_W-1:0]  va,
  input  logic             is_data,
  input  logic             is_write,
  input  logic             hit,
  input  logic [4:0]       page_shift,
  input  logic [PFN_W-1:0] pfn_even,
  input  logic [PFN_W-1:0] pfn_odd,
  input  logic             valid_even,
  input  logic             valid_odd,
  input  logic             dirty_even,
  input  logic             dirty_odd,
  output fault_e           fault,
  output logic [PA_W-1:0]  pa
);
  localparam int PAD_W = PA_W - PFN_W;

  logic             odd_sel;
  logic [PFN_W-1:0] frame;
  logic             half_ok;
  logic             half_wr;
  logic [PA_W-1:0]  frame_wide;
  logic [PA_W-1:0]  off_mask;

  assign odd_sel    = va[page_shift];
  assign frame      = odd_sel ? pfn_odd : pfn_even;
  assign half_ok    = odd_sel ? valid_odd : valid_even;
  assign half_wr    = odd_sel ? dirty_odd : dirty_even;
  assign frame_wide = ({{PAD_W{1'b0}}, frame} >> (page_shift - 5'(BASE_SHIFT))) << page_shift;
  assign off_mask   = (PA_W'(1) << page_shift) - PA_W'(1);

  always_comb begin
    fault = F_NONE;
    pa    = '0;
    if (!hit)
      fault = is_data ? F_REFILL_D : F_REFILL_I;
    else if (!half_ok)
      fault = is_data ? F_INVAL_D : F_INVAL_I;
    else if (is_write && !half_wr)
      fault = F_MOD;
    else
      pa = frame_wide | (va[PA_W-1:0] & off_mask);
  end
endmodule

// File: rtl/vaddr_xlate.sv
module vaddr_xlate
  import xlate_pkg::*;
#(
  parameter int ASID_W = 8,
  parameter int PFN_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic [1:0]        req_kind,
  input  logic              req_misaligned,
  input  logic [ASID_W-1:0] req_asid,
  input  logic [31:0]       status_word,
  input  logic              small_pages,
  output logic [VPN_W-1:0]  probe_vpn,
  output logic [ASID_W-1:0] probe_asid,
  input  logic              ent_hit,
  input  logic [4:0]        ent_page_shift,
  input  logic [PFN_W-1:0]  ent_pfn_even,
  input  logic [PFN_W-1:0]  ent_pfn_odd,
  input  logic              ent_valid_even,
  input  logic              ent_valid_odd,
  input  logic              ent_dirty_even,
  input  logic              ent_dirty_odd,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [PA_W-1:0]   resp_pa,
  output logic              resp_uncached,
  output logic [3:0]        resp_fault,
  output logic [VA_W-1:0]   resp_bad_va,
  output logic [VPN2_W-1:0] resp_vpn2,
  output logic [1:0]        resp_vpn2x,
  output logic [ASID_W-1:0] resp_asid
);
  op_mode_e        mode;
  logic            in_kwin_priv, in_kwin_open;
  logic [PA_W-1:0] direct_pa, mapped_pa;
  fault_e          mapped_fault;
  logic            is_data, is_write, accept;

  fault_e            nx_fault;
  logic [PA_W-1:0]   nx_pa;
  logic              nx_unc, tbl_fault;
  logic [VA_W-1:0]   nx_bad_va;
  logic [VPN2_W-1:0] nx_vpn2;
  logic [1:0]        nx_vpn2x;
  logic [ASID_W-1:0] nx_asid;

  assign is_data   = (req_kind != 2'd0);
  assign is_write  = (req_kind == 2'd2);
  assign req_ready = !resp_valid || resp_ready;
  assign accept    = req_valid && req_ready;

  assign probe_vpn  = small_pages ? req_va[VA_W-1:11] : {req_va[VA_W-1:13], 2'b00};
  assign probe_asid = req_asid;

  xlate_mode_dec u_mode (.status_word(status_word), .mode(mode));

  xlate_segment u_seg (
    .va(req_va), .in_kwin_priv(in_kwin_priv), .in_kwin_open(in_kwin_open),
    .direct_pa(direct_pa)
  );

  xlate_page_map #(.PFN_W(PFN_W)) u_map (
    .va(req_va), .is_data(is_data), .is_write(is_write), .hit(ent_hit),
    .page_shift(ent_page_shift), .pfn_even(ent_pfn_even), .pfn_odd(ent_pfn_odd),
    .valid_even(ent_valid_even), .valid_odd(ent_valid_odd),
    .dirty_even(ent_dirty_even), .dirty_odd(ent_dirty_odd),
    .fault(mapped_fault), .pa(mapped_pa)
  );

  always_comb begin
    nx_fault = F_NONE;
    nx_pa    = '0;
    if (in_kwin_priv) begin
      if (mode != MODE_KERN || req_misaligned)
        nx_fault = is_data ? F_ADDR_D : F_ADDR_I;
      else
        nx_pa = direct_pa;
    end else if (in_kwin_open) begin
      nx_pa = direct_pa;
    end else if (req_misaligned) begin
      nx_fault = is_data ? F_ADDR_D : F_ADDR_I;
    end else begin
      nx_fault = mapped_fault;
      nx_pa    = mapped_pa;
    end
    tbl_fault = (nx_fault != F_NONE) && (nx_fault != F_ADDR_I) && (nx_fault != F_ADDR_D);
    nx_unc    = (nx_fault == F_NONE) && ((req_va & UNCACHE_PAT) == UNCACHE_PAT);
    nx_bad_va = (nx_fault != F_NONE) ? req_va : '0;
    nx_vpn2   = tbl_fault ? probe_vpn[VPN_W-1:2] : '0;
    nx_vpn2x  = tbl_fault ? probe_vpn[1:0] : '0;
    nx_asid   = tbl_fault ? req_asid : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid    <= 1'b0;
      resp_pa       <= '0;
      resp_uncached <= 1'b0;
      resp_fault    <= 4'd0;
      resp_bad_va   <= '0;
      resp_vpn2     <= '0;
      resp_vpn2x    <= '0;
      resp_asid     <= '0;
    end else if (req_ready) begin
      resp_valid <= req_valid;
      if (accept) begin
        resp_pa       <= nx_pa;
        resp_uncached <= nx_unc;
        resp_fault    <= nx_fault;
        resp_bad_va   <= nx_bad_va;
        resp_vpn2     <= nx_vpn2;
        resp_vpn2x    <= nx_vpn2x;
        resp_asid     <= nx_asid;
      end
    end
  end

  assert_stall_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_pa) &&
      $stable(resp_fault) && $stable(resp_bad_va) && $stable(resp_uncached));

  assert_open_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (req_va[31:29] == 3'b101) |=> resp_valid && (resp_fault == 4'd0) &&
      (resp_pa == {3'b000, $past(req_va[28:0])}));

  assert_misalign_mapped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_misaligned && (req_va[31:30] != 2'b10) |=>
      (resp_fault == 4'd1) || (resp_fault == 4'd2));

  assert_report_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && (resp_fault >= 4'd3) |-> resp_vpn2 == resp_bad_va[31:13]);

  assert_fault_zero_pa_R12: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && (resp_fault != 4'd0) |-> (resp_pa == '0) && !resp_uncached);
endmodule

// File: tb/vaddr_xlate_tb_top.sv
`timescale 1ns/1ps
module vaddr_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_va = '0;
  logic [1:0]  req_kind = '0;
  logic        req_misaligned = 1'b0;
  logic [7:0]  req_asid = '0;
  logic [31:0] status_word = '0;
  logic        small_pages = 1'b0;
  logic [20:0] probe_vpn;
  logic [7:0]  probe_asid;
  logic        ent_hit = 1'b0;
  logic [4:0]  ent_page_shift = 5'd12;
  logic [19:0] ent_pfn_even = '0, ent_pfn_odd = '0;
  logic        ent_valid_even = 1'b0, ent_valid_odd = 1'b0;
  logic        ent_dirty_even = 1'b0, ent_dirty_odd = 1'b0;
  logic        resp_valid, resp_ready = 1'b1;
  logic [31:0] resp_pa;
  logic        resp_uncached;
  logic [3:0]  resp_fault;
  logic [31:0] resp_bad_va;
  logic [18:0] resp_vpn2;
  logic [1:0]  resp_vpn2x;
  logic [7:0]  resp_asid;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  vaddr_xlate dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic set_ent(input logic hit, input logic [4:0] sh, input logic [19:0] p0,
                         input logic [19:0] p1, input logic v0, input logic v1,
                         input logic d0, input logic d1);
    ent_hit = hit; ent_page_shift = sh; ent_pfn_even = p0; ent_pfn_odd = p1;
    ent_valid_even = v0; ent_valid_odd = v1; ent_dirty_even = d0; ent_dirty_odd = d1;
  endtask

  task automatic xact(input logic [31:0] va, input logic [1:0] kind, input logic mis,
                      input logic [7:0] asid, input logic [31:0] st, input logic sp);
    @(negedge clk);
    req_va = va; req_kind = kind; req_misaligned = mis; req_asid = asid;
    status_word = st; small_pages = sp; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_res(input string tag, input logic [31:0] pa,
                            input logic [3:0] f, input logic unc);
    chk({tag, " valid"}, 32'(resp_valid), 32'd1);
    chk({tag, " pa"}, resp_pa, pa);
    chk({tag, " fault"}, 32'(resp_fault), 32'(f));
    chk({tag, " uncached"}, 32'(resp_uncached), 32'(unc));
  endtask

  task automatic t_reset();
    chk("R1 reset resp_valid", 32'(resp_valid), 32'd0);
    chk("R1 reset req_ready", 32'(req_ready), 32'd1);
  endtask

  task automatic t_direct_windows();
    xact(32'hA000_1234, 2'd1, 1'b0, 8'h00, 32'h10, 1'b0);
    expect_res("R4 R11 open window user", 32'h0000_1234, 4'd0, 1'b1);
    xact(32'hB000_0003, 2'd2, 1'b1, 8'h00, 32'h18, 1'b0);
    expect_res("R4 open window misaligned", 32'h1000_0003, 4'd0, 1'b1);
    xact(32'h8000_4000, 2'd0, 1'b0, 8'h00, 32'h0, 1'b0);
    expect_res("R4 R11 priv window kernel", 32'h0000_4000, 4'd0, 1'b0);
  endtask

  task automatic t_modes();
    xact(32'h8000_0100, 2'd0, 1'b0, 8'h00, 32'h10, 1'b0);
    expect_res("R3 user fetch", 32'h0, 4'd1, 1'b0);
    chk("R10 addr err bad_va", resp_bad_va, 32'h8000_0100);
    chk("R10 addr err vpn2", 32'(resp_vpn2), 32'h0);
    chk("R10 addr err asid", 32'(resp_asid), 32'h0);
    xact(32'h8000_0100, 2'd1, 1'b0, 8'h00, 32'h08, 1'b0);
    expect_res("R3 supervisor load", 32'h0, 4'd2, 1'b0);
    xact(32'h8000_0100, 2'd2, 1'b0, 8'h00, 32'h18, 1'b0);
    expect_res("R3 invalid mode store", 32'h0, 4'd2, 1'b0);
    xact(32'h8000_0100, 2'd1, 1'b0, 8'h00, 32'h12, 1'b0);
    expect_res("R3 kernel via mask bit", 32'h0000_0100, 4'd0, 1'b0);
    xact(32'h9000_0100, 2'd1, 1'b0, 8'h00, 32'h1000_0018, 1'b0);
    expect_res("R3 kernel via high bit", 32'h1000_0100, 4'd0, 1'b0);
    xact(32'h8000_0101, 2'd0, 1'b1, 8'h00, 32'h0, 1'b0);
    expect_res("R3 kernel misaligned", 32'h0, 4'd1, 1'b0);
  endtask

  task automatic t_misaligned_mapped();
    set_ent(1'b1, 5'd12, 20'h00111, 20'h00222, 1'b1, 1'b1, 1'b1, 1'b1);
    xact(32'h0040_0001, 2'd0, 1'b1, 8'h03, 32'h10, 1'b0);
    expect_res("R5 R12 mapped misaligned fetch", 32'h0, 4'd1, 1'b0);
    set_ent(1'b0, 5'd12, 20'h0, 20'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    xact(32'hC040_0002, 2'd2, 1'b1, 8'h03, 32'h10, 1'b0);
    expect_res("R5 R12 misaligned beats refill", 32'h0, 4'd2, 1'b0);
  endtask

  task automatic t_refill();
    set_ent(1'b0, 5'd12, 20'h0, 20'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    req_va = 32'h1234_6800; req_asid = 8'h5A; small_pages = 1'b0;
    #1 chk("R2 probe vpn large", 32'(probe_vpn), 32'h2468C);
    chk("R2 probe asid", 32'(probe_asid), 32'h5A);
    small_pages = 1'b1;
    #1 chk("R2 probe vpn small", 32'(probe_vpn), 32'h2468D);
    xact(32'h1234_6800, 2'd0, 1'b0, 8'h5A, 32'h10, 1'b0);
    expect_res("R6 refill fetch", 32'h0, 4'd3, 1'b0);
    chk("R10 bad_va", resp_bad_va, 32'h1234_6800);
    chk("R10 vpn2", 32'(resp_vpn2), 32'h91A3);
    chk("R10 vpn2x large", 32'(resp_vpn2x), 32'h0);
    chk("R10 asid", 32'(resp_asid), 32'h5A);
    xact(32'h1234_6800, 2'd1, 1'b0, 8'h5A, 32'h10, 1'b1);
    expect_res("R6 refill load", 32'h0, 4'd4, 1'b0);
    chk("R10 vpn2x small", 32'(resp_vpn2x), 32'h1);
  endtask

  task automatic t_halves();
    set_ent(1'b1, 5'd12, 20'h00ABC, 20'h00DEF, 1'b1, 1'b0, 1'b1, 1'b1);
    xact(32'h0040_1000, 2'd0, 1'b0, 8'h07, 32'h10, 1'b0);
    expect_res("R7 odd invalid fetch", 32'h0, 4'd5, 1'b0);
    chk("R10 invalid asid", 32'(resp_asid), 32'h07);
    xact(32'h0040_1000, 2'd1, 1'b0, 8'h07, 32'h10, 1'b0);
    expect_res("R7 odd invalid load", 32'h0, 4'd6, 1'b0);
    xact(32'h0040_0123, 2'd1, 1'b0, 8'h07, 32'h10, 1'b0);
    expect_res("R7 R9 even valid", 32'h00AB_C123, 4'd0, 1'b0);
    chk("R10 no fault bad_va", resp_bad_va, 32'h0);
  endtask

  task automatic t_pa_forming();
    set_ent(1'b1, 5'd14, 20'h12347, 20'h0, 1'b1, 1'b0, 1'b1, 1'b0);
    xact(32'h0040_2ABC, 2'd1, 1'b0, 8'h01, 32'h10, 1'b0);
    expect_res("R9 shift14 even", 32'h1234_6ABC, 4'd0, 1'b0);
    set_ent(1'b1, 5'd12, 20'h0, 20'h00ABC, 1'b0, 1'b1, 1'b0, 1'b1);
    xact(32'hE000_1010, 2'd2, 1'b0, 8'h01, 32'h10, 1'b0);
    expect_res("R11 mapped uncached", 32'h00AB_C010, 4'd0, 1'b1);
  endtask

  task automatic t_dirty();
    set_ent(1'b1, 5'd12, 20'h00555, 20'h00666, 1'b1, 1'b0, 1'b0, 1'b0);
    xact(32'h0040_0010, 2'd2, 1'b0, 8'h22, 32'h10, 1'b0);
    expect_res("R8 store clean page", 32'h0, 4'd7, 1'b0);
    chk("R10 mod vpn2", 32'(resp_vpn2), 32'h200);
    xact(32'h0040_0010, 2'd1, 1'b0, 8'h22, 32'h10, 1'b0);
    expect_res("R8 load ignores dirty", 32'h0055_5010, 4'd0, 1'b0);
    xact(32'h0040_0010, 2'd0, 1'b0, 8'h22, 32'h10, 1'b0);
    expect_res("R8 fetch ignores dirty", 32'h0055_5010, 4'd0, 1'b0);
    xact(32'h0040_1010, 2'd2, 1'b0, 8'h22, 32'h10, 1'b0);
    expect_res("R12 invalid beats modified", 32'h0, 4'd6, 1'b0);
    set_ent(1'b1, 5'd12, 20'h00555, 20'h00666, 1'b1, 1'b0, 1'b1, 1'b0);
    xact(32'h0040_0010, 2'd2, 1'b0, 8'h22, 32'h10, 1'b0);
    expect_res("R8 store dirty page", 32'h0055_5010, 4'd0, 1'b0);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    resp_ready = 1'b0;
    req_va = 32'hA000_0010; req_kind = 2'd1; req_misaligned = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    chk("R1 first result valid", 32'(resp_valid), 32'd1);
    chk("R1 ready drops", 32'(req_ready), 32'd0);
    req_va = 32'hA000_0020;
    @(negedge clk);
    chk("R1 stall holds pa", resp_pa, 32'h10);
    chk("R1 still not ready", 32'(req_ready), 32'd0);
    resp_ready = 1'b1;
    #1 chk("R1 ready follows resp_ready", 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 second result", resp_pa, 32'h20);
    chk("R1 second valid", 32'(resp_valid), 32'd1);
    @(negedge clk);
    chk("R1 drains", 32'(resp_valid), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_direct_windows();
    t_modes();
    t_misaligned_mapped();
    t_refill();
    t_halves();
    t_pa_forming();
    t_dirty();
    t_backpressure();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule